// File: doc/BRIEF.md
# Shift Register Slice with Register-versus-Bus Comparator

This block is an 8-bit storage slice. Two select lines pick one of four operations on each rising clock edge. The slice can hold its value, shift it one place toward the least significant end, load it from a parallel bus, or drive it back onto that bus. The bus is split into an input vector, an output vector and an output-enable bit. The tri-state buffer is left to the level above.

A comparator checks the stored value against the bus. It reports equal, greater-than and less-than as three registered, true-high flags. A compare-mode input selects signed two's-complement or unsigned ordering. The signed reading applies only in the slice that holds the top bits of a wider word. The flags can be switched off with an active-low enable. A valid output replaces the open-collector wired-AND behaviour: the flags are driven only while it is high.

One linking input and one linking output serve two purposes. During a shift they carry serial data between neighbouring slices. In every other mode they carry a priority signal down the chain. A more significant slice that has already found a difference tells the slices below it to keep their flags off. Only the slice that decides the result reports it.

Top module: `scmp_slice`

## Requirements
- R1: With select code 2'b10, the register takes the value of `bus_in` at the rising clock edge.
- R2: With select code 2'b01, the register shifts one place at the edge. `link_in` enters at bit 7 and bits 7..1 move to bits 6..0. While the code is 2'b01, `link_out` shows register bit 0 without a clock delay.
- R3: With select code 2'b00, the register keeps its value whatever `bus_in` carries.
- R4: With select code 2'b11, the register is unchanged. One cycle after the edge, `bus_oe` is 1 and `bus_out` equals the register. In every other mode, both outputs are 0 one cycle after the edge.
- R5: One cycle after each edge, the flags reflect the register and `bus_in` as they were at that edge. When `flags_valid` is 1, exactly one of `flag_eq`, `flag_gt` and `flag_lt` is 1. When `flags_valid` is 0, all three are 0.
- R6: When `cmp_signed`=1 and `slice_is_top`=1, the comparison is two's-complement, so 8'h80 is less than 8'h7F. In all other cases the comparison is unsigned.
- R7: With select code 2'b11, the register is compared with itself, so `flag_eq` is 1 whatever `bus_in` carries.
- R8: When `stat_en_n` is 1 at an edge, all three flags and `flags_valid` are 0 in the next cycle.
- R9: In any mode other than shift, `link_out` = `link_in` OR (register not equal to `bus_in`), without a clock delay. If `link_in` is 1 at an edge, all flags and `flags_valid` are 0 in the next cycle. In shift mode, `link_in` suppresses nothing.
- R10: Synchronous active-high `rst` clears the register, `bus_out`, `bus_oe`, the flags and `flags_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift, 10 load, 11 read out |
| bus_in | input | 8 | Value seen on the parallel bus |
| bus_out | output | 8 | Register value driven toward the bus during read out |
| bus_oe | output | 1 | Bus output enable |
| link_in | input | 1 | Serial data in (shift) or priority from the more significant slice |
| link_out | output | 1 | Serial data out (shift) or priority to the less significant slice |
| cmp_signed | input | 1 | 1 selects two's-complement compare |
| slice_is_top | input | 1 | 1 marks the slice holding the sign bit |
| stat_en_n | input | 1 | Active-low enable for the compare flags |
| flag_eq | output | 1 | Register equals bus |
| flag_gt | output | 1 | Register greater than bus |
| flag_lt | output | 1 | Register less than bus |
| flags_valid | output | 1 | Flags are being driven |

## Verification
The comparator is tested with value pairs chosen to tell signed ordering from unsigned ordering. 8'h80 against 8'h7F and 8'h00 against 8'hFF give opposite results in the two modes. The same pairs are also run on a slice marked not-top, which shows that the sign treatment is confined to the top slice. Equal values and values one apart confirm that the flags are exclusive and have no off-by-one error. Separate patterns drive `bus_in` away from the register during hold and read out. A known bit pattern is shifted in and out through the link pins. Priority inputs are applied with the register both equal and unequal to the bus, which tells suppression apart from propagation.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_LOAD  = 2'b10,
    OP_READ  = 2'b11
  } slice_op_t;
endpackage

// File: rtl/scmp_store.sv
module scmp_store
  import scmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  slice_op_t        op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= par_in;
        OP_SHIFT: q <= {ser_in, q[WIDTH-1:1]};
        default:  q <= q;
      endcase
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_READ) |=> $stable(q)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q == $past(par_in))); // R1
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (q == {$past(ser_in), $past(q[WIDTH-1:1])})); // R2
endmodule

// File: rtl/scmp_compare.sv
module scmp_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             use_sign,
  output logic             eq,
  output logic             gt,
  output logic             lt
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] a_k, b_k;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  always_comb begin
    a_k = use_sign ? (a ^ TOP_BIT) : a;
    b_k = use_sign ? (b ^ TOP_BIT) : b;
    eq  = (a_k == b_k);
    gt  = (a_k > b_k);
    lt  = (a_k < b_k);
  end
endmodule

// File: rtl/scmp_status.sv
module scmp_status (
  input  logic clk,
  input  logic rst,
  input  logic eq_in,
  input  logic gt_in,
  input  logic lt_in,
  input  logic stat_en_n,
  input  logic suppress,
  output logic eq_q,
  output logic gt_q,
  output logic lt_q,
  output logic valid_q
);
  logic drive;
  assign drive = !stat_en_n && !suppress;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q    <= 1'b0;
      gt_q    <= 1'b0;
      lt_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      eq_q    <= drive & eq_in;
      gt_q    <= drive & gt_in;
      lt_q    <= drive & lt_in;
      valid_q <= drive;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ($countones({eq_q, gt_q, lt_q}) == 1)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> ({eq_q, gt_q, lt_q} == 3'b000)); // R5
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    stat_en_n |=> !valid_q); // R8
  AST_PRIORITY_GATES: assert property (@(posedge clk) disable iff (rst)
    suppress |=> !valid_q); // R9
endmodule

// File: rtl/scmp_slice.sv
module scmp_slice
  import scmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  input  logic             link_in,
  output logic             link_out,
  input  logic             cmp_signed,
  input  logic             slice_is_top,
  input  logic             stat_en_n,
  output logic             flag_eq,
  output logic             flag_gt,
  output logic             flag_lt,
  output logic             flags_valid
);
  slice_op_t        op;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] cmp_b;
  logic             c_eq, c_gt, c_lt;
  logic             use_sign;
  logic             suppress;

  assign op = slice_op_t'(mode_sel);

  scmp_store #(.WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .par_in (bus_in),
    .ser_in (link_in),
    .q      (reg_q)
  );

  // During read out the bus carries the register itself.
  assign cmp_b    = (op == OP_READ) ? reg_q : bus_in;
  assign use_sign = cmp_signed & slice_is_top;

  scmp_compare #(.WIDTH(WIDTH)) u_cmp (
    .a        (reg_q),
    .b        (cmp_b),
    .use_sign (use_sign),
    .eq       (c_eq),
    .gt       (c_gt),
    .lt       (c_lt)
  );

  assign suppress = (op != OP_SHIFT) & link_in;
  assign link_out = (op == OP_SHIFT) ? reg_q[0] : (link_in | ~c_eq);

  scmp_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .eq_in     (c_eq),
    .gt_in     (c_gt),
    .lt_in     (c_lt),
    .stat_en_n (stat_en_n),
    .suppress  (suppress),
    .eq_q      (flag_eq),
    .gt_q      (flag_gt),
    .lt_q      (flag_lt),
    .valid_q   (flags_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= (op == OP_READ);
      bus_out <= (op == OP_READ) ? reg_q : '0;
    end
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ) |=> (bus_oe && bus_out == $past(reg_q))); // R4
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (op != OP_READ) |=> (!bus_oe && bus_out == '0)); // R4
  AST_READ_SELF_EQ: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ && !stat_en_n && !link_in) |=> flag_eq); // R7
endmodule

// File: tb/tb_scmp_slice.sv
module tb_scmp_slice;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic [7:0] bus_in;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic       link_in;
  logic       link_out;
  logic       cmp_signed;
  logic       slice_is_top;
  logic       stat_en_n;
  logic       flag_eq, flag_gt, flag_lt, flags_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scmp_slice dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .link_in(link_in), .link_out(link_out),
    .cmp_signed(cmp_signed), .slice_is_top(slice_is_top), .stat_en_n(stat_en_n),
    .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt), .flags_valid(flags_valid)
  );

  // {reg value, bus value, signed, top slice, exp eq, exp gt, exp lt}
  localparam logic [20:0] VEC [0:7] = '{
    {8'h35, 8'h35, 1'b0, 1'b1, 3'b100},
    {8'h80, 8'h7F, 1'b0, 1'b1, 3'b010},
    {8'h80, 8'h7F, 1'b1, 1'b1, 3'b001},
    {8'h80, 8'h7F, 1'b1, 1'b0, 3'b010},
    {8'h00, 8'hFF, 1'b0, 1'b1, 3'b001},
    {8'h00, 8'hFF, 1'b1, 1'b1, 3'b010},
    {8'hFF, 8'hFE, 1'b1, 1'b1, 3'b010},
    {8'h12, 8'h13, 1'b0, 1'b1, 3'b001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    mode_sel = 2'b10;
    bus_in = v;
    step();
  endtask

  task automatic read_check(input string req, input logic [7:0] exp);
    mode_sel = 2'b11;
    step();
    check(req, {23'd0, bus_oe, bus_out}, {23'd0, 1'b1, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_sel = 2'b00; bus_in = 8'h00; link_in = 1'b0;
    cmp_signed = 1'b0; slice_is_top = 1'b1; stat_en_n = 1'b0;
    step(); step();
    rst = 1'b0;
    // R10 reset state
    check("R10 outputs", {bus_oe, bus_out, flag_eq, flag_gt, flag_lt, flags_valid},
          {1'b0, 8'h00, 4'b0000});
    read_check("R10 register zero", 8'h00);

    // Comparison table: R5, R6
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][20:13]);
      mode_sel = 2'b00;
      bus_in = VEC[i][12:5];
      cmp_signed = VEC[i][4];
      slice_is_top = VEC[i][3];
      step();
      check($sformatf("R5 R6 vector %0d", i),
            {flags_valid, flag_eq, flag_gt, flag_lt}, {1'b1, VEC[i][2:0]});
    end
    cmp_signed = 1'b0; slice_is_top = 1'b1;

    // R1 load then R4 read out, R7 self-compare with bus held different
    load(8'hA5);
    mode_sel = 2'b11; bus_in = 8'h00;
    step();
    check("R4 read drives", {bus_oe, bus_out}, {1'b1, 8'hA5});
    check("R7 self equal", {flags_valid, flag_eq, flag_gt, flag_lt}, 4'b1100);
    mode_sel = 2'b00;
    step();
    check("R4 idle after read", {bus_oe, bus_out}, {1'b0, 8'h00});

    // R3 hold ignores bus
    load(8'h3C);
    mode_sel = 2'b00; bus_in = 8'hFF;
    step(); step();
    read_check("R3 hold keeps value", 8'h3C);

    // R9 priority linking in non-shift mode (register = 3C)
    mode_sel = 2'b00; bus_in = 8'h10; link_in = 1'b1;
    #1 check("R9 link out unequal", {31'd0, link_out}, 32'd1);
    step();
    check("R9 suppressed flags", {flags_valid, flag_eq, flag_gt, flag_lt}, 4'b0000);
    bus_in = 8'h3C;
    #1 check("R9 link propagates", {31'd0, link_out}, 32'd1);
    link_in = 1'b0;
    #1 check("R9 link low when equal", {31'd0, link_out}, 32'd0);
    bus_in = 8'h10;
    #1 check("R9 link high unequal", {31'd0, link_out}, 32'd1);
    step();
    check("R9 unsuppressed flags", {flags_valid, flag_eq, flag_gt, flag_lt}, 4'b1010);

    // R8 status enable
    stat_en_n = 1'b1;
    step();
    check("R8 flags off", {flags_valid, flag_eq, flag_gt, flag_lt}, 4'b0000);
    stat_en_n = 1'b0;

    // R2 shift: B4 -> DA (in 1) -> 6D (in 0)
    load(8'hB4);
    mode_sel = 2'b01; link_in = 1'b1;
    #1 check("R2 serial out bit0 of B4", {31'd0, link_out}, 32'd0);
    step();
    check("R2 shift keeps flags driven", {31'd0, flags_valid}, 32'd1);
    link_in = 1'b0;
    #1 check("R2 serial out bit0 of DA", {31'd0, link_out}, 32'd0);
    step();
    #1 check("R2 serial out bit0 of 6D", {31'd0, link_out}, 32'd1);
    read_check("R2 shifted value", 8'h6D);

    // R10 reset mid-operation
    load(8'h77);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R10 flags after reset", {31'd0, flags_valid}, 32'd0);
    read_check("R10 register cleared", 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule